// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block forms the memory address for a load or store micro-op of a RISC-style pipeline and, alongside it, the updated base value that the register file would write back. It takes a base register value, an offset that comes either from a sign-extended immediate or from a register, and a handful of control bits. The control bits choose pre- or post-indexing, request base writeback, and pick add or subtract and the shift direction and amount for a register offset. A PC-relative form replaces the base with the address of the instruction plus the pipeline lead of the program counter.

The unit sits between operand read and the memory stage. Decode, register file access and the memory access itself happen elsewhere. Each accepted request produces one registered result one clock later, marked by a valid flag. All address arithmetic is 32-bit and wraps silently.

Top module: `ldst_addr_unit`

## Requirements
- R1: While reset is asserted (rst_n low), out_valid, wb_en, eff_addr and wb_value are all zero.
- R2: A request presented with in_valid high produces out_valid high on the next clock edge. A cycle with in_valid low produces out_valid low on the next edge.
- R3: In pre-index mode (post_idx=0, pc_rel=0), eff_addr and wb_value both equal base + offset. wb_en equals wb_req.
- R4: In post-index mode (post_idx=1, pc_rel=0), eff_addr equals the unmodified base and wb_value equals base + offset. wb_en is 1 whatever wb_req is.
- R5: With off_is_reg=1 the register offset is shifted before use. shift_right=0 selects a logical left shift and shift_right=1 selects a logical right shift. The shift amount is the 5-bit unsigned shamt, 0 to 31.
- R6: With off_is_reg=1, sub_off=1 subtracts the shifted register offset from the base and sub_off=0 adds it. With off_is_reg=0, sub_off has no effect.
- R7: With off_is_reg=0 the offset is the 12-bit imm_off field, read as two's complement and sign-extended to 32 bits.
- R8: With pc_rel=1 the base is instr_addr + 8 and base_val is ignored. The request is treated as pre-index whatever post_idx is, so eff_addr = wb_value = instr_addr + 8 + offset, and wb_en is 0.
- R9: Address sums and differences wrap modulo 2^32 with no overflow indication.
- R10: After a cycle with in_valid low, wb_en is 0 and eff_addr and wb_value keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is present this cycle |
| base_val | input | 32 | Base register value |
| instr_addr | input | 32 | Address of the instruction, used in PC-relative form |
| pc_rel | input | 1 | 1: base is instr_addr + 8, no writeback |
| off_is_reg | input | 1 | 1: register offset, 0: immediate offset |
| imm_off | input | 12 | Signed immediate offset |
| reg_off | input | 32 | Register offset value before shifting |
| shift_right | input | 1 | 0: logical left shift, 1: logical right shift |
| shamt | input | 5 | Shift amount for the register offset |
| sub_off | input | 1 | 1: subtract the register offset |
| post_idx | input | 1 | 1: post-index, 0: pre-index |
| wb_req | input | 1 | Writeback request in pre-index mode |
| out_valid | output | 1 | Registered result is valid |
| eff_addr | output | 32 | Effective address |
| wb_value | output | 32 | New base value |
| wb_en | output | 1 | Base writeback enable |

## Verification
Several corners are hard to reach: a PC-relative request that also asks for post-indexing and writeback, a subtracted register offset that wraps below zero, and a subtract flag set on an immediate request. None of them arises from ordinary address patterns. The stimulus sets these control combinations on purpose. It uses base values near 0 and near 2^32, and shift amounts of 0 and 31. It also places idle cycles between requests, so that the output holding behaviour is tested against a model that runs on every clock.

// File: rtl/ldst_addr_pkg.sv
package ldst_addr_pkg;
    localparam int ADDR_W_DEF   = 32;
    localparam int IMM_W_DEF    = 12;
    localparam int SHAMT_W_DEF  = 5;
    localparam int PC_AHEAD_DEF = 8;

    typedef enum logic {
        SHK_LEFT  = 1'b0,
        SHK_RIGHT = 1'b1
    } shift_kind_e;
endpackage

// File: rtl/ldst_off_gen.sv
module ldst_off_gen
    import ldst_addr_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int IMM_W   = IMM_W_DEF,
    parameter int SHAMT_W = SHAMT_W_DEF
) (
    input  logic               off_is_reg,
    input  logic [IMM_W-1:0]   imm_off,
    input  logic [ADDR_W-1:0]  reg_off,
    input  shift_kind_e        kind,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               sub_off,
    output logic [ADDR_W-1:0]  addend
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_ext;
    logic [ADDR_W-1:0] shifted;

    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_ext = {{EXT_W{imm_off[IMM_W-1]}}, imm_off};
        end else begin : g_noext
            assign imm_ext = imm_off[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        if (kind == SHK_RIGHT) shifted = reg_off >> shamt;
        else                   shifted = reg_off << shamt;
    end

    always_comb begin
        if (!off_is_reg)  addend = imm_ext;
        else if (sub_off) addend = ~shifted + {{(ADDR_W-1){1'b0}}, 1'b1};
        else              addend = shifted;
    end
endmodule

// File: rtl/ldst_base_sel.sv
module ldst_base_sel #(
    parameter int ADDR_W   = 32,
    parameter int PC_AHEAD = 8
) (
    input  logic              pc_rel,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] instr_addr,
    output logic [ADDR_W-1:0] base
);
    localparam logic [ADDR_W-1:0] LEAD = ADDR_W'(PC_AHEAD);

    always_comb begin
        base = pc_rel ? (instr_addr + LEAD) : base_val;
    end
endmodule

// File: rtl/ldst_addr_unit.sv
module ldst_addr_unit
    import ldst_addr_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int IMM_W    = IMM_W_DEF,
    parameter int SHAMT_W  = SHAMT_W_DEF,
    parameter int PC_AHEAD = PC_AHEAD_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic [ADDR_W-1:0]  instr_addr,
    input  logic               pc_rel,
    input  logic               off_is_reg,
    input  logic [IMM_W-1:0]   imm_off,
    input  logic [ADDR_W-1:0]  reg_off,
    input  logic               shift_right,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               sub_off,
    input  logic               post_idx,
    input  logic               wb_req,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  eff_addr,
    output logic [ADDR_W-1:0]  wb_value,
    output logic               wb_en
);
    typedef struct packed {
        logic              valid;
        logic              wb_en;
        logic [ADDR_W-1:0] ea;
        logic [ADDR_W-1:0] wbv;
    } stage_t;

    stage_t            st_d, st_q;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] addend;
    logic [ADDR_W-1:0] sum;
    logic              post_eff;

    ldst_base_sel #(
        .ADDR_W   (ADDR_W),
        .PC_AHEAD (PC_AHEAD)
    ) u_base (
        .pc_rel     (pc_rel),
        .base_val   (base_val),
        .instr_addr (instr_addr),
        .base       (base)
    );

    ldst_off_gen #(
        .ADDR_W  (ADDR_W),
        .IMM_W   (IMM_W),
        .SHAMT_W (SHAMT_W)
    ) u_off (
        .off_is_reg (off_is_reg),
        .imm_off    (imm_off),
        .reg_off    (reg_off),
        .kind       (shift_kind_e'(shift_right)),
        .shamt      (shamt),
        .sub_off    (sub_off),
        .addend     (addend)
    );

    always_comb begin
        sum      = base + addend;
        post_eff = post_idx && !pc_rel;
        st_d     = st_q;
        st_d.valid = in_valid;
        st_d.wb_en = 1'b0;
        if (in_valid) begin
            st_d.ea    = post_eff ? base : sum;
            st_d.wbv   = sum;
            st_d.wb_en = !pc_rel && (post_idx || wb_req);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign wb_en     = st_q.wb_en;
    assign eff_addr  = st_q.ea;
    assign wb_value  = st_q.wbv;
endmodule

// File: rtl/ldst_addr_chk.sv
module ldst_addr_chk #(
    parameter int ADDR_W   = 32,
    parameter int IMM_W    = 12,
    parameter int SHAMT_W  = 5,
    parameter int PC_AHEAD = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [ADDR_W-1:0]  base_val,
    input logic [ADDR_W-1:0]  instr_addr,
    input logic               pc_rel,
    input logic               off_is_reg,
    input logic [IMM_W-1:0]   imm_off,
    input logic [ADDR_W-1:0]  reg_off,
    input logic               shift_right,
    input logic [SHAMT_W-1:0] shamt,
    input logic               sub_off,
    input logic               post_idx,
    input logic               wb_req,
    input logic               out_valid,
    input logic [ADDR_W-1:0]  eff_addr,
    input logic [ADDR_W-1:0]  wb_value,
    input logic               wb_en
);
    logic [ADDR_W-1:0] imm_sx;
    assign imm_sx = {{(ADDR_W-IMM_W){imm_off[IMM_W-1]}}, imm_off};

    a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r3_pre_same: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !post_idx) |=> (eff_addr == wb_value));
    a_r4_post_base: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && post_idx && !pc_rel) |=> (eff_addr == $past(base_val) && wb_en));
    a_r7_imm_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !off_is_reg && !pc_rel && !post_idx)
        |=> (eff_addr == $past(base_val + imm_sx)));
    a_r8_pc_nowb: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pc_rel) |=> (!wb_en && eff_addr == wb_value));
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(eff_addr) && $stable(wb_value) && !wb_en));
endmodule

bind ldst_addr_unit ldst_addr_chk #(
    .ADDR_W   (ADDR_W),
    .IMM_W    (IMM_W),
    .SHAMT_W  (SHAMT_W),
    .PC_AHEAD (PC_AHEAD)
) u_chk (.*);

// File: tb/tb_ldst_addr_unit.sv
module tb_ldst_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic [31:0] instr_addr = '0;
    logic        pc_rel = 1'b0;
    logic        off_is_reg = 1'b0;
    logic [11:0] imm_off = '0;
    logic [31:0] reg_off = '0;
    logic        shift_right = 1'b0;
    logic [4:0]  shamt = '0;
    logic        sub_off = 1'b0;
    logic        post_idx = 1'b0;
    logic        wb_req = 1'b0;
    logic        out_valid, wb_en;
    logic [31:0] eff_addr, wb_value;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_tag = "R1";

    // reference model state
    logic        m_valid = 0, m_wb = 0;
    logic [31:0] m_ea = '0, m_wbv = '0;
    string       m_tag = "R1";

    always #2.5 clk = ~clk;

    ldst_addr_unit dut (.*);

    function automatic logic [31:0] offset_of();
        logic [31:0] v;
        if (off_is_reg) begin
            v = shift_right ? (reg_off >> shamt) : (reg_off << shamt);
            if (sub_off) v = 32'd0 - v;
        end else begin
            v = 32'($signed(imm_off));
        end
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_valid <= 0; m_wb <= 0; m_ea <= '0; m_wbv <= '0;
        end else begin
            m_tag <= cur_tag;
            m_valid <= in_valid;
            if (in_valid) begin
                logic [31:0] b;
                logic [31:0] s;
                b = pc_rel ? instr_addr + 32'd8 : base_val;
                s = b + offset_of();
                m_ea  <= (post_idx && !pc_rel) ? b : s;
                m_wbv <= s;
                m_wb  <= !pc_rel && (post_idx || wb_req);
            end else begin
                m_wb <= 0;
            end
        end
    end

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // compare on every falling edge; R2 covers the valid flag
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp(m_tag, "R2 out_valid", 32'(out_valid), 32'(m_valid));
            cmp(m_tag, "wb_en", 32'(wb_en), 32'(m_wb));
            cmp(m_tag, "eff_addr", eff_addr, m_ea);
            cmp(m_tag, "wb_value", wb_value, m_wbv);
        end
    end

    task automatic req(string tag, logic [31:0] b, logic [31:0] ia, logic pr,
                       logic isr, logic [11:0] imm, logic [31:0] ro, logic sr,
                       logic [4:0] sa, logic sb, logic po, logic wr);
        @(negedge clk);
        cur_tag = tag; in_valid = 1; base_val = b; instr_addr = ia; pc_rel = pr;
        off_is_reg = isr; imm_off = imm; reg_off = ro; shift_right = sr;
        shamt = sa; sub_off = sb; post_idx = po; wb_req = wr;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cur_tag = "R10"; in_valid = 0;
            base_val = base_val ^ 32'h5A5A_0F0F; reg_off = ~reg_off;
        end
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        cmp("R1", "out_valid", 32'(out_valid), 32'd0);
        cmp("R1", "wb_en", 32'(wb_en), 32'd0);
        cmp("R1", "eff_addr", eff_addr, 32'd0);
        cmp("R1", "wb_value", wb_value, 32'd0);
        rst_n = 1;
        idle(2);
        // R3 pre-index, immediate, with and without writeback
        req("R3", 32'd1000, 0, 0, 0, 12'd200, 0, 0, 0, 0, 0, 0);
        req("R3", 32'd2012, 0, 0, 0, 12'hFFC, 0, 0, 0, 0, 0, 1);
        // R7 negative and maximum immediates
        req("R7", 32'h0000_1000, 0, 0, 0, 12'h800, 0, 0, 0, 0, 0, 0);
        req("R7", 32'h0000_1000, 0, 0, 0, 12'h7FF, 0, 0, 0, 0, 0, 1);
        // R4 post-index, register offset LSL 2, wb_req low
        req("R4", 32'd1000, 0, 0, 1, 0, 32'd25, 0, 5'd2, 0, 1, 0);
        req("R4", 32'd1100, 0, 0, 0, 12'd4, 0, 0, 0, 0, 1, 1);
        idle(1);
        // R5 shifts at amount extremes
        req("R5", 32'd0, 0, 0, 1, 0, 32'h8000_0001, 1, 5'd31, 0, 0, 0);
        req("R5", 32'd16, 0, 0, 1, 0, 32'h0000_0003, 0, 5'd31, 0, 0, 1);
        req("R5", 32'd16, 0, 0, 1, 0, 32'h1234_5678, 0, 5'd0, 0, 0, 0);
        req("R5", 32'd16, 0, 0, 1, 0, 32'hF000_0000, 1, 5'd4, 0, 1, 0);
        // R6 subtract register offset; sub_off ignored for immediate
        req("R6", 32'd1200, 0, 0, 1, 0, 32'd200, 0, 0, 1, 0, 0);
        req("R6", 32'd1200, 0, 0, 1, 0, 32'd50, 0, 5'd2, 1, 1, 0);
        req("R6", 32'd1200, 0, 0, 0, 12'd16, 0, 0, 0, 1, 0, 0);
        // R9 wrap above and below
        req("R9", 32'hFFFF_FFF0, 0, 0, 1, 0, 32'h20, 0, 0, 0, 0, 1);
        req("R9", 32'h0000_0004, 0, 0, 1, 0, 32'h10, 0, 0, 1, 1, 0);
        idle(3);
        // R8 PC-relative, base_val ignored, post/wb requests ignored
        req("R8", 32'hDEAD_BEEF, 32'd1000, 1, 0, 12'd52, 0, 0, 0, 0, 0, 0);
        req("R8", 32'h1111_1111, 32'd1000, 1, 0, 12'd52, 0, 0, 0, 0, 1, 1);
        req("R8", 32'h0, 32'hFFFF_FFFC, 1, 1, 0, 32'd3, 0, 5'd1, 1, 0, 1);
        idle(2);
        // R2 back-to-back mixed then idle
        req("R2", 32'd500, 0, 0, 0, 12'd1, 0, 0, 0, 0, 1, 0);
        req("R2", 32'd500, 0, 0, 0, 12'd2, 0, 0, 0, 0, 0, 1);
        idle(3);
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule